// File: doc/BRIEF.md
# Matrix Keypad Scan Engine

This block scans a switch matrix of up to eight rows by eight columns and keeps one filtered status bit for every crossing. A control word sets the enable, the pull polarity, the number of active rows and columns, and two optional filters. An I/O-control word picks which side of the matrix is driven and which of its pins get output enables. The engine moves one step per driven line. It puts the active level on that line, waits for the sense lines to settle, samples them, and then moves to the next line. The other lines sit at the idle level, which is the level the pull resistors give.

The status bits hold line levels, not "pressed" flags. The idle level is 1 with pull-ups and 0 with pull-downs, so the meaning of a bit depends on the pull mode. Two status words carry all 64 bits. A slow scan tick of about 31.25 kHz paces the engine. All state is clocked by the system clock, and the engine only acts on cycles where the tick is high.

Top module: `keypad_scan`

## Requirements
- R1: Key (r, c) sits in `status_lo` for rows 0 to 3 and in `status_hi` for rows 4 to 7, at bit index (r mod 4)*8 + c.
- R2: Control bit 1 set selects pull-up: the idle level is 1 and a pressed key reads 0. Control bit 1 clear selects pull-down: the idle level is 0 and a pressed key reads 1.
- R3: Rows are driven when I/O-control bits 31:24 are nonzero; otherwise columns are driven. The driven side's output enables equal its mask: bits 31:24 for rows, bits 23:16 for columns. The other side's enables are 0. At most one enabled line carries the active level (the inverse of idle), and every other driven line stays at idle.
- R4: Control bits 22:20 hold the row count minus one and bits 18:16 hold the column count minus one. Only lines below the driven side's count are ever driven active, in ascending order, wrapping to line 0. With the sense-line filter off, each step lasts two scan ticks: one settle tick, then one sample tick.
- R5: Status bits of keys whose row or column lies beyond the configured counts always read the idle level.
- R6: When control bit 15 is set, a status bit changes only after 2^code consecutive scan cycles sample the same new level, where the code is control bits 14:12. A shorter glitch is rejected. When bit 15 is clear, the bit takes each new sample directly.
- R7: When control bit 11 is set, each step waits 2^code scan ticks before sampling, where the code is control bits 10:8. The wait restarts when the sense lines change between ticks.
- R8: While control bit 0 is clear, all output enables are 0. From the next clock on, every status bit reads idle, and scanning restarts at line 0 when re-enabled. Reset leaves the same state.
- R9: With columns driven, the row lines are sensed, and the status layout and polarity are the same as with rows driven.
- R10: Status words change only on clock edges where the scan tick is high, or when the control word itself changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | One-cycle pacing strobe, about 31.25 kHz |
| ctrl_word | input | 32 | Enable, pull mode, counts and filter settings |
| io_ctrl_word | input | 32 | Row (31:24) and column (23:16) output-enable masks |
| row_in | input | 8 | Sensed row line levels |
| col_in | input | 8 | Sensed column line levels |
| row_out | output | 8 | Row drive values |
| row_oe | output | 8 | Row output enables |
| col_out | output | 8 | Column drive values |
| col_oe | output | 8 | Column output enables |
| status_lo | output | 32 | Status of rows 0 to 3 |
| status_hi | output | 32 | Status of rows 4 to 7 |

## Verification
A stuck or skipped step index shows up on the drive pins within two scan ticks. It appears as a line that never goes active, as a line above the count going active, or as a dwell other than eight clocks. A wrong per-key filter count or pressed flag reaches the status words only after one full debounce window. For that reason the bench presses keys on a matrix model and waits a computed number of scan cycles before comparing every status bit. A bad enable or range gate is visible on the next clock, because both the output enables and the idle status are decoded from the control word.

// File: rtl/keypad_scan_pkg.sv
// Package: shared constants and the decoded control-word record for the
// keypad scan engine. Assumes the fixed 8x8 matrix and 3-bit filter codes.
package keypad_scan_pkg;

    localparam int KP_LINES  = 8;                  // maximum rows and columns
    localparam int KP_IDX_W  = $clog2(KP_LINES);   // line index width
    localparam int KP_CODE_W = 3;                  // filter period code width
    localparam int KP_KEYS   = KP_LINES * KP_LINES;

    typedef struct packed {
        logic                 enable;
        logic                 pull_up;
        logic [KP_IDX_W-1:0]  row_last;
        logic [KP_IDX_W-1:0]  col_last;
        logic                 sense_filt_on;
        logic [KP_CODE_W-1:0] sense_code;
        logic                 stat_filt_on;
        logic [KP_CODE_W-1:0] stat_code;
    } kp_cfg_t;

    // Pull the used fields out of the 32-bit control word.
    function automatic kp_cfg_t kp_decode(input logic [31:0] w);
        kp_cfg_t c;
        c.enable        = w[0];
        c.pull_up       = w[1];
        c.row_last      = w[22:20];
        c.col_last      = w[18:16];
        c.sense_filt_on = w[11];
        c.sense_code    = w[10:8];
        c.stat_filt_on  = w[15];
        c.stat_code     = w[14:12];
        return c;
    endfunction

endpackage

// File: rtl/keypad_scan_seq.sv
// Step sequencer: holds the index of the driven line and decides on which
// scan tick the sense lines are sampled. Without the sense filter a step is
// one settle tick then one sample tick. With it the wait is 2^code ticks and
// restarts on any change of the sense lines. Assumes scan_tick is a
// one-cycle strobe.
module keypad_scan_seq
    import keypad_scan_pkg::*;
#(
    parameter int LINES  = KP_LINES,
    parameter int CODE_W = KP_CODE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        tick,
    input  logic [$clog2(LINES)-1:0]    last_step,
    input  logic                        filt_on,
    input  logic [CODE_W-1:0]           filt_code,
    input  logic [LINES-1:0]            sense,
    output logic [$clog2(LINES)-1:0]    step,
    output logic                        sample
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int WAIT_W = 2 ** CODE_W;   // holds 2^(2^CODE_W - 1)

    logic [WAIT_W-1:0] wait_cnt;
    logic [WAIT_W-1:0] wait_need;
    logic [LINES-1:0]  sense_prev;
    logic              sense_moved;

    // Number of ticks to wait before sampling, and change detection.
    always_comb begin
        wait_need   = filt_on ? (WAIT_W'(1) << filt_code) : WAIT_W'(1);
        sense_moved = filt_on && (sense != sense_prev);
        sample      = en && tick && !sense_moved && (wait_cnt == wait_need);
    end

    // Advance the wait counter and the step index on scan ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step       <= '0;
            wait_cnt   <= '0;
            sense_prev <= '0;
        end else if (!en) begin
            step       <= '0;
            wait_cnt   <= '0;
            sense_prev <= sense;
        end else if (tick) begin
            sense_prev <= sense;
            if (sense_moved) begin
                wait_cnt <= WAIT_W'(1);
            end else if (wait_cnt == wait_need) begin
                wait_cnt <= '0;
                step     <= (step >= last_step) ? '0 : step + IDX_W'(1);
            end else begin
                wait_cnt <= wait_cnt + WAIT_W'(1);
            end
        end
    end

endmodule

// File: rtl/keypad_scan_drive.sv
// Line driver: puts the active level on the selected line of the driven
// side and the idle level everywhere else. Output enables follow the mask of
// the driven side while scanning. Purely combinational.
module keypad_scan_drive #(
    parameter int LINES = 8
) (
    input  logic                        en,
    input  logic                        pull_up,
    input  logic                        drive_rows,
    input  logic [$clog2(LINES)-1:0]    step,
    input  logic [LINES-1:0]            row_mask,
    input  logic [LINES-1:0]            col_mask,
    output logic [LINES-1:0]            row_out,
    output logic [LINES-1:0]            row_oe,
    output logic [LINES-1:0]            col_out,
    output logic [LINES-1:0]            col_oe
);
    logic [LINES-1:0] idle_v;
    logic [LINES-1:0] drive_v;

    // Build the drive pattern and route it to the chosen side.
    always_comb begin
        idle_v  = {LINES{pull_up}};
        drive_v = en ? (idle_v ^ (LINES'(1) << step)) : idle_v;
        row_out = drive_rows ? drive_v : idle_v;
        col_out = drive_rows ? idle_v : drive_v;
        row_oe  = (en && drive_rows)  ? row_mask : '0;
        col_oe  = (en && !drive_rows) ? col_mask : '0;
    end

endmodule

// File: rtl/keypad_key_cell.sv
// Per-key filter: keeps a "differs from idle" flag for one key. With the
// filter on, the flag flips only after 2^code consecutive samples of the new
// value. Assumes hit pulses at most once per scan cycle for this key.
module keypad_key_cell #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hit,
    input  logic              level,
    input  logic              pull_up,
    input  logic              filt_on,
    input  logic [CODE_W-1:0] filt_code,
    output logic              active
);
    localparam int PER_W = 2 ** CODE_W - 1;   // holds 2^code - 1

    logic [PER_W-1:0] run_cnt;
    logic [PER_W-1:0] run_last;
    logic             fresh;

    // Sample relative to idle, and the last count before a flip.
    always_comb begin
        fresh    = level ^ pull_up;
        run_last = {PER_W{1'b1}} >> (PER_W - int'(filt_code));
    end

    // Count consecutive differing samples and flip the flag at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active  <= 1'b0;
            run_cnt <= '0;
        end else if (hit) begin
            if (!filt_on) begin
                active  <= fresh;
                run_cnt <= '0;
            end else if (fresh == active) begin
                run_cnt <= '0;
            end else if (run_cnt == run_last) begin
                active  <= fresh;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + PER_W'(1);
            end
        end
    end

endmodule

// File: rtl/keypad_scan.sv
// Keypad scan engine top: decodes the control words and runs the sequencer
// and the line driver. It holds one filter cell per matrix key and packs
// the per-key levels into two status words, rows 0-3 low and rows 4-7 high,
// eight bits per row. Keys outside the configured counts read idle.
module keypad_scan
    import keypad_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scan_tick,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] io_ctrl_word,
    input  logic [7:0]  row_in,
    input  logic [7:0]  col_in,
    output logic [7:0]  row_out,
    output logic [7:0]  row_oe,
    output logic [7:0]  col_out,
    output logic [7:0]  col_oe,
    output logic [31:0] status_lo,
    output logic [31:0] status_hi
);
    localparam int HALF = KP_KEYS / 2;

    kp_cfg_t              cfg;
    logic                 drive_rows;
    logic [KP_LINES-1:0]  row_mask;
    logic [KP_LINES-1:0]  col_mask;
    logic [KP_LINES-1:0]  sense;
    logic [KP_IDX_W-1:0]  step;
    logic [KP_IDX_W-1:0]  last_step;
    logic                 sample;
    logic [KP_KEYS-1:0]   key_level;
    logic                 unused_bits;

    // Decode configuration and pick the sensed side.
    always_comb begin
        cfg        = kp_decode(ctrl_word);
        row_mask   = io_ctrl_word[31:24];
        col_mask   = io_ctrl_word[23:16];
        drive_rows = |row_mask;
        sense      = drive_rows ? col_in : row_in;
        last_step  = drive_rows ? cfg.row_last : cfg.col_last;
    end

    assign unused_bits = ^{ctrl_word[31:23], ctrl_word[19], ctrl_word[7:2],
                           io_ctrl_word[15:0]};

    keypad_scan_seq #(.LINES(KP_LINES), .CODE_W(KP_CODE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.enable),
        .tick      (scan_tick),
        .last_step (last_step),
        .filt_on   (cfg.sense_filt_on),
        .filt_code (cfg.sense_code),
        .sense     (sense),
        .step      (step),
        .sample    (sample)
    );

    keypad_scan_drive #(.LINES(KP_LINES)) u_drive (
        .en         (cfg.enable),
        .pull_up    (cfg.pull_up),
        .drive_rows (drive_rows),
        .step       (step),
        .row_mask   (row_mask),
        .col_mask   (col_mask),
        .row_out    (row_out),
        .row_oe     (row_oe),
        .col_out    (col_out),
        .col_oe     (col_oe)
    );

    for (genvar gr = 0; gr < KP_LINES; gr++) begin : g_row
        for (genvar gc = 0; gc < KP_LINES; gc++) begin : g_col
            logic in_rng;
            logic hit;
            logic level;
            logic active;

            assign in_rng = (KP_IDX_W'(gr) <= cfg.row_last) &&
                            (KP_IDX_W'(gc) <= cfg.col_last);
            assign hit    = sample && in_rng &&
                            (drive_rows ? (step == KP_IDX_W'(gr))
                                        : (step == KP_IDX_W'(gc)));
            assign level  = drive_rows ? col_in[gc] : row_in[gr];

            keypad_key_cell #(.CODE_W(KP_CODE_W)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (cfg.enable),
                .hit       (hit),
                .level     (level),
                .pull_up   (cfg.pull_up),
                .filt_on   (cfg.stat_filt_on),
                .filt_code (cfg.stat_code),
                .active    (active)
            );

            assign key_level[gr*KP_LINES+gc] = (active && in_rng) ^ cfg.pull_up;
        end
    end

    assign status_lo = key_level[HALF-1:0];
    assign status_hi = key_level[KP_KEYS-1:HALF];

endmodule

// File: rtl/keypad_scan_checker.sv
// Port-level checker for keypad_scan, bound to every instance of it.
// Assumes rst_n is held low from time zero until the first clock edges.
module keypad_scan_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scan_tick,
    input logic [31:0] ctrl_word,
    input logic [7:0]  row_out,
    input logic [7:0]  row_oe,
    input logic [7:0]  col_out,
    input logic [7:0]  col_oe,
    input logic [31:0] status_lo,
    input logic [31:0] status_hi
);
    // R3: never more than one enabled line away from idle
    a_r3_one_active_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({row_oe & (row_out ^ {8{ctrl_word[1]}}),
                    col_oe & (col_out ^ {8{ctrl_word[1]}})}) <= 1);

    // R3: only one side has output enables
    a_r3_single_side: assert property (@(posedge clk) disable iff (!rst_n)
        !((|row_oe) && (|col_oe)));

    // R8: disabled means no output enables
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[0] |-> (row_oe == 8'h00 && col_oe == 8'h00));

    // R8: status returns to idle one clock after disable
    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[0] |=> (ctrl_word[0] ||
            {status_hi, status_lo} == {64{ctrl_word[1]}}));

    // R10: no status change on an edge without a scan tick
    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_tick && ctrl_word[0]) |=>
            (!$stable(ctrl_word) || $stable({status_hi, status_lo})));

    // R5: row 7 reads idle whenever fewer than eight rows are configured
    a_r5_row7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[22:20] != 3'd7) |-> (status_hi[31:24] == {8{ctrl_word[1]}}));

endmodule

bind keypad_scan keypad_scan_checker u_keypad_scan_checker (.*);

// File: tb/keypad_scan_bench.sv
// Bench: a matrix model closes keys between the driven and sensed lines,
// and expected status words are computed from the pressed-key map.
module keypad_scan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick;
    logic [1:0]  tick_cnt = 2'd0;
    logic [31:0] ctrl = 32'd0;
    logic [31:0] io = 32'd0;
    logic [7:0]  rin, cin;
    logic [7:0]  row_out, row_oe, col_out, col_oe;
    logic [31:0] status_lo, status_hi;
    logic [63:0] pressed = 64'd0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    // Scan tick: one clock in four.
    always @(posedge clk) tick_cnt <= tick_cnt + 2'd1;
    assign scan_tick = (tick_cnt == 2'd3);

    keypad_scan u_keypad_scan (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
        .ctrl_word(ctrl), .io_ctrl_word(io),
        .row_in(rin), .col_in(cin),
        .row_out(row_out), .row_oe(row_oe), .col_out(col_out), .col_oe(col_oe),
        .status_lo(status_lo), .status_hi(status_hi)
    );

    // Matrix model: a pressed key pulls its sense line to the active level.
    always_comb begin
        logic idl;
        idl = ctrl[1];
        rin = {8{idl}};
        cin = {8{idl}};
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                if (pressed[r*8+c]) begin
                    if (row_oe[r] && (row_out[r] != idl)) cin[c] = ~idl;
                    if (col_oe[c] && (col_out[c] != idl)) rin[r] = ~idl;
                end
            end
        end
    end

    function automatic logic [31:0] mk_ctrl(input logic en, input logic pu,
            input int rows, input int cols, input logic cfe, input int cc,
            input logic sfe, input int sc);
        logic [31:0] w;
        w = 32'd0;
        w[0] = en;
        w[1] = pu;
        w[22:20] = 3'(rows - 1);
        w[18:16] = 3'(cols - 1);
        w[11] = cfe;
        w[10:8] = 3'(cc);
        w[15] = sfe;
        w[14:12] = 3'(sc);
        return w;
    endfunction

    function automatic logic [63:0] exp_st(input logic pu, input int rows,
            input int cols, input logic [63:0] prs);
        logic [63:0] e;
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                e[(r/4)*32 + (r%4)*8 + c] =
                    (r < rows && c < cols && prs[r*8+c]) ? ~pu : pu;
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    // Wait long enough for (period) filter cycles over n lines.
    task automatic settle(input int n, input int step_need, input int period);
        run_ticks((period + 2) * n * (step_need + 2));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] held;
        logic [7:0]  seen;
        logic [7:0]  act;
        logic [7:0]  prev;
        int          dwell;

        repeat (5) @(negedge clk);
        chk("R8 reset status", {status_hi, status_lo}, 64'd0);
        chk("R8 reset oe", {48'd0, row_oe, col_oe}, 64'd0);
        rst_n = 1'b1;

        // R1 R2 R9 sweep: single key in a 4x4 matrix, both pulls, both sides.
        for (int pu = 0; pu < 2; pu++) begin
            for (int side = 0; side < 2; side++) begin
                io = (side == 0) ? 32'h0F00_0000 : 32'h000F_0000;
                pressed = 64'd0;
                ctrl = mk_ctrl(1'b1, 1'(pu), 4, 4, 1'b0, 0, 1'b0, 0);
                settle(4, 1, 1);
                chk("R3 oe mask", {48'd0, row_oe, col_oe},
                    (side == 0) ? 64'h0F00 : 64'h000F);
                chk("R2 idle level", {status_hi, status_lo},
                    exp_st(1'(pu), 4, 4, pressed));
                for (int k = 0; k < 16; k++) begin
                    pressed = 64'd1 << ((k / 4) * 8 + (k % 4));
                    settle(4, 1, 1);
                    chk((side == 0) ? "R1 R2 row-driven key" : "R9 column-driven key",
                        {status_hi, status_lo}, exp_st(1'(pu), 4, 4, pressed));
                end
            end
        end

        // R5 R4: 3 rows x 5 columns, keys in and out of range.
        io = 32'hFF00_0000;
        ctrl = mk_ctrl(1'b1, 1'b0, 3, 5, 1'b0, 0, 1'b0, 0);
        pressed = 64'd0;
        pressed[0*8+0] = 1'b1;
        pressed[1*8+2] = 1'b1;
        pressed[2*8+4] = 1'b1;
        settle(3, 1, 1);
        chk("R4 three rows five cols", {status_hi, status_lo}, exp_st(1'b0, 3, 5, pressed));
        pressed = 64'd0;
        pressed[5*8+1] = 1'b1;
        pressed[2*8+6] = 1'b1;
        pressed[7*8+7] = 1'b1;
        pressed[1*8+1] = 1'b1;
        settle(3, 1, 1);
        chk("R5 out of range idle", {status_hi, status_lo}, 64'd1 << 9);

        // R4: only lines 0..2 go active; each step lasts two ticks.
        pressed = 64'd0;
        seen = 8'd0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            seen = seen | (row_oe & row_out);
        end
        chk("R4 lines visited", {56'd0, seen}, 64'h07);
        prev = row_oe & row_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            act = row_oe & row_out;
            if (act != prev) break;
        end
        prev = row_oe & row_out;
        dwell = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            dwell++;
            act = row_oe & row_out;
            if (act != prev) break;
        end
        chk("R4 step dwell clocks", 64'(dwell), 64'd8);
        chk("R3 one active line", 64'($countones(row_oe & row_out)), 64'd1);

        // R10: a press between ticks cannot move status.
        io = 32'h0F00_0000;
        ctrl = mk_ctrl(1'b1, 1'b1, 4, 4, 1'b0, 0, 1'b0, 0);
        pressed = 64'd0;
        settle(4, 1, 1);
        while (scan_tick !== 1'b1) @(negedge clk);
        @(negedge clk);
        held = {status_hi, status_lo};
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) pressed[r*8+c] = (r == c);
        @(negedge clk);
        chk("R10 hold between ticks", {status_hi, status_lo}, held);
        settle(4, 1, 1);
        chk("R10 diagonal after ticks", {status_hi, status_lo},
            exp_st(1'b1, 4, 4, pressed));

        // R6: status filter with period 4 cycles (cycle = 8 ticks).
        pressed = 64'd0;
        ctrl = mk_ctrl(1'b1, 1'b1, 4, 4, 1'b0, 0, 1'b1, 2);
        settle(4, 1, 4);
        pressed[2*8+1] = 1'b1;
        run_ticks(16);
        chk("R6 held before window", {status_hi, status_lo}, {64{1'b1}});
        run_ticks(48);
        chk("R6 change after window", {status_hi, status_lo},
            exp_st(1'b1, 4, 4, pressed));
        pressed = 64'd0;
        run_ticks(8);
        pressed[2*8+1] = 1'b1;
        run_ticks(64);
        chk("R6 glitch rejected", {status_hi, status_lo},
            exp_st(1'b1, 4, 4, pressed));
        ctrl = mk_ctrl(1'b1, 1'b1, 4, 4, 1'b0, 0, 1'b0, 2);
        pressed = 64'd0;
        run_ticks(17);
        chk("R6 filter off follows", {status_hi, status_lo}, {64{1'b1}});

        // R7: sense filter 8 ticks; key on row 3 sampled late after enable.
        ctrl = mk_ctrl(1'b0, 1'b0, 4, 4, 1'b1, 3, 1'b0, 0);
        pressed = 64'd0;
        pressed[3*8+0] = 1'b1;
        run_ticks(2);
        ctrl[0] = 1'b1;
        run_ticks(20);
        chk("R7 not yet sampled", {status_hi, status_lo}, 64'd0);
        run_ticks(60);
        chk("R7 sampled after wait", {status_hi, status_lo},
            exp_st(1'b0, 4, 4, pressed));

        // R8: disable forces idle status and no enables; re-enable recovers.
        ctrl[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 disabled oe", {48'd0, row_oe, col_oe}, 64'd0);
        chk("R8 disabled status", {status_hi, status_lo}, 64'd0);
        ctrl[0] = 1'b1;
        settle(4, 8, 1);
        chk("R8 re-enabled", {status_hi, status_lo}, exp_st(1'b0, 4, 4, pressed));

        summary();
    end

endmodule